// File: doc/BRIEF.md
# Partitioned Memory Address Interleaver

This block sits between a two-lane request crossbar and eight memory-controller ports. Each lane carries a 33-bit byte address and a write flag. The block turns each request into three things: a crossbar port (which selects a cache slice), a controller index with a controller-local address, and a partition tag. Addresses at or above 4 GB are sent to a host-bus path and do not reach local DRAM.

The block has two mapping modes. In the full mode, 1 KB granules rotate across all eight ports. In the degraded mode, one slice is fused off. The lower 3584 MB is then striped evenly over the seven remaining ports, using the granule number modulo 7. The top 512 MB goes only to the orphaned eighth controller, which is reached through the seventh port's slice over a buddy link.

Reads to the lower and upper partitions must never be presented in the same cycle. When they compete, the block grants them in alternation. Writes are not subject to this rule. The mode input is taken only while the block is idle.

Top module: `pmi_interleaver`

## Requirements
- R1: With degraded_i low, a request below 4 GB with granule number g = addr[31:10] goes to port g mod 8 and controller g mod 8, with local address (g div 8)*1024 + addr[9:0] and partition tag 0 (lower).
- R2: With degraded mode in effect, a request below 3584 MB (0xE000_0000) goes to port and controller g mod 7, with local address (g div 7)*1024 + addr[9:0] and tag 0.
- R3: With degraded mode in effect, a request from 0xE000_0000 up to 0xFFFF_FFFF goes to port 6 (the buddy slice) and controller 7, with local address addr − 0xE000_0000 and tag 1 (upper).
- R4: In either mode, a request with addr[32] set goes to port code 8 (host), controller 0, tag 2, and an unchanged address.
- R5: Two outputs are never valid in the same cycle as reads with tags 0 and 1. A lower or upper read whose opposite-partition read is stalled on the other lane's output sees ready low.
- R6: When both lanes offer reads to opposite partitions in one cycle, exactly one is accepted. The first such clash after reset grants the lower read, and later clashes alternate between upper and lower.
- R7: Writes are exempt from the partition exclusion. A write and an opposite-partition read offered together are both accepted.
- R8: While a lane's output is valid and out_rdy_i is low, that lane's req_rdy_o is low and its output holds its value. The result of an accepted request appears at the output one cycle after acceptance.
- R9: The mode used for mapping changes only in a cycle with no valid output and no valid request. A degraded_i change made while busy does not affect requests accepted before the block becomes idle.
- R10: After reset, no output is valid and both lanes are ready, and the full mode is in effect.
- R11: Over 7·k consecutive granules in degraded mode, each of ports 0 to 6 receives exactly k requests. A port never receives two consecutive granules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| degraded_i | input | 1 | 1 selects seven-port striping with buddy upper partition |
| req_vld_i | input | 2 | Request valid per lane |
| req_rdy_o | output | 2 | Request ready per lane |
| req_addr_i | input | 2x33 | Byte address per lane |
| req_wr_i | input | 2 | 1 = write, 0 = read, per lane |
| out_vld_o | output | 2 | Routed request valid per lane |
| out_rdy_i | input | 2 | Downstream ready per lane |
| out_port_o | output | 2x4 | Crossbar port 0..7, or 8 for host |
| out_ctrl_o | output | 2x3 | Target memory controller |
| out_part_o | output | 2x2 | Partition tag: 0 lower, 1 upper, 2 host |
| out_wr_o | output | 2 | Write flag carried through |
| out_addr_o | output | 2x33 | Controller-local address, or full address for host |

## Verification
Some rules are checked by assertions on every cycle. These are the partition exclusion on the two outputs, output holding and lane ready under backpressure, the rule that the buddy route uses only port 6 with controller 7 and host traffic uses only port code 8, the rule that a clash grants exactly one lane, and agreement between the digit-folding remainder and a direct modulo. Other behaviour can only be shown by the bench scenarios. This covers the exact addresses at the partition edges, the even spread of sequential granules over seven ports, the alternation order of clash grants, write exemption, and mode changes deferred until idle.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  localparam int ADDR_W  = 33;
  localparam int GRAN_W  = 10;
  localparam int LANE_N  = 2;
  localparam int PORT_N  = 8;
  localparam int SEL_W   = $clog2(PORT_N);
  localparam int PORT_W  = SEL_W + 1;
  localparam int DRAM_W  = ADDR_W - 1;
  localparam int CTRL_W  = DRAM_W - SEL_W;
  localparam int GNUM_W  = DRAM_W - GRAN_W;

  localparam logic [DRAM_W-1:0] LOWER_TOP   = {SEL_W'(PORT_N - 1), {CTRL_W{1'b0}}};
  localparam logic [PORT_W-1:0] HOST_PORT   = PORT_W'(PORT_N);
  localparam logic [PORT_W-1:0] BUDDY_PORT  = PORT_W'(PORT_N - 2);
  localparam logic [SEL_W-1:0]  ORPHAN_CTRL = SEL_W'(PORT_N - 1);

  typedef enum logic [1:0] {
    PART_LO   = 2'd0,
    PART_HI   = 2'd1,
    PART_HOST = 2'd2
  } part_e;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [SEL_W-1:0]  ctrl;
    part_e             part;
    logic              wr;
    logic [ADDR_W-1:0] loc;
  } route_t;
endpackage

// File: rtl/pmi_mod7.sv
module pmi_mod7 #(
  parameter int W = 22
) (
  input  logic [W-1:0] val_i,
  output logic [2:0]   rem_o
);
  localparam int DIG_N = (W + 2) / 3;
  localparam int PAD_W = DIG_N * 3;
  localparam int SUM_W = $clog2(7 * DIG_N + 1) < 3 ? 3 : $clog2(7 * DIG_N + 1);

  logic [PAD_W-1:0]          pad;
  logic [DIG_N-1:0][2:0]     dig;
  logic [SUM_W-1:0]          sum;
  logic [SUM_W-1:0]          fold;

  assign pad = PAD_W'(val_i);

  // base-8 digits: since 8 is 1 modulo 7, their sum keeps the remainder
  for (genvar d = 0; d < DIG_N; d++) begin : g_dig
    assign dig[d] = pad[3*d +: 3];
  end

  always_comb begin
    sum = '0;
    for (int d = 0; d < DIG_N; d++) begin
      sum = sum + SUM_W'(dig[d]);
    end
    fold = sum;
    for (int k = 0; k < SUM_W; k++) begin
      fold = SUM_W'(fold >> 3) + SUM_W'(fold[2:0]);
    end
    rem_o = (fold[2:0] == 3'd7) ? 3'd0 : fold[2:0];
  end
endmodule

// File: rtl/pmi_map.sv
module pmi_map
  import pmi_pkg::*;
(
  input  logic              degraded_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output route_t            route_o
);
  logic [GNUM_W-1:0] gnum;
  logic [GRAN_W-1:0] off;
  logic [DRAM_W-1:0] dram;
  logic [GNUM_W-1:0] quot;
  logic [2:0]        rem;

  assign gnum = addr_i[DRAM_W-1:GRAN_W];
  assign off  = addr_i[GRAN_W-1:0];
  assign dram = addr_i[DRAM_W-1:0];
  assign quot = gnum / GNUM_W'(7);

  pmi_mod7 #(.W(GNUM_W)) u_mod7 (
    .val_i (gnum),
    .rem_o (rem)
  );

  always_comb begin
    route_o.wr = wr_i;
    if (addr_i[ADDR_W-1]) begin
      route_o.port = HOST_PORT;
      route_o.ctrl = '0;
      route_o.part = PART_HOST;
      route_o.loc  = addr_i;
    end else if (!degraded_i) begin
      route_o.port = PORT_W'(gnum[SEL_W-1:0]);
      route_o.ctrl = gnum[SEL_W-1:0];
      route_o.part = PART_LO;
      route_o.loc  = ADDR_W'({gnum[GNUM_W-1:SEL_W], off});
    end else if (dram >= LOWER_TOP) begin
      route_o.port = BUDDY_PORT;
      route_o.ctrl = ORPHAN_CTRL;
      route_o.part = PART_HI;
      route_o.loc  = ADDR_W'(dram - LOWER_TOP);
    end else begin
      route_o.port = PORT_W'(rem);
      route_o.ctrl = SEL_W'(rem);
      route_o.part = PART_LO;
      route_o.loc  = ADDR_W'({quot, off});
    end
  end
endmodule

// File: rtl/pmi_excl.sv
module pmi_excl
  import pmi_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANE_N-1:0]      in_vld_i,
  input  logic [LANE_N-1:0]      in_wr_i,
  input  logic [LANE_N-1:0][1:0] in_part_i,
  input  logic [LANE_N-1:0]      o_vld_i,
  input  logic [LANE_N-1:0]      o_rdy_i,
  input  logic [LANE_N-1:0]      o_wr_i,
  input  logic [LANE_N-1:0][1:0] o_part_i,
  output logic [LANE_N-1:0]      acc_o,
  output logic [LANE_N-1:0]      rdy_o
);
  logic [LANE_N-1:0] free, rd_in, held, blk, cand, lose;
  logic              clash;
  logic              rr_q, rr_n;
  logic [1:0]        fav;

  assign fav   = rr_q ? 2'(PART_HI) : 2'(PART_LO);
  assign clash = cand[0] && cand[1] && rd_in[0] && rd_in[1] &&
                 (in_part_i[0] != in_part_i[1]);

  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    localparam int J = LANE_N - 1 - i;
    assign free[i]  = !o_vld_i[i] || o_rdy_i[i];
    assign rd_in[i] = in_vld_i[i] && !in_wr_i[i] && (in_part_i[i] != 2'(PART_HOST));
    assign held[i]  = o_vld_i[i] && !o_rdy_i[i] && !o_wr_i[i] &&
                      (o_part_i[i] != 2'(PART_HOST));
    assign blk[i]   = rd_in[i] && held[J] && (o_part_i[J] != in_part_i[i]);
    assign cand[i]  = in_vld_i[i] && free[i] && !blk[i];
    assign lose[i]  = clash && (in_part_i[i] != fav);
    assign acc_o[i] = cand[i] && !lose[i];
    assign rdy_o[i] = free[i] && !blk[i] && !lose[i];
  end

  always_comb begin
    rr_n = rr_q;
    if (clash) rr_n = !rr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= 1'b0;
    else        rr_q <= rr_n;
  end

  // R6
  clash_one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> ($countones(acc_o) == 1));

  // R6
  clash_valid_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> ($countones(rdy_o) == 1));
endmodule

// File: rtl/pmi_interleaver.sv
module pmi_interleaver
  import pmi_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        degraded_i,
  input  logic [LANE_N-1:0]           req_vld_i,
  output logic [LANE_N-1:0]           req_rdy_o,
  input  logic [LANE_N-1:0][ADDR_W-1:0] req_addr_i,
  input  logic [LANE_N-1:0]           req_wr_i,
  output logic [LANE_N-1:0]           out_vld_o,
  input  logic [LANE_N-1:0]           out_rdy_i,
  output logic [LANE_N-1:0][PORT_W-1:0] out_port_o,
  output logic [LANE_N-1:0][SEL_W-1:0]  out_ctrl_o,
  output logic [LANE_N-1:0][1:0]      out_part_o,
  output logic [LANE_N-1:0]           out_wr_o,
  output logic [LANE_N-1:0][ADDR_W-1:0] out_addr_o
);
  logic [1:0]              rst_sync;
  logic                    rst_q;
  logic                    mode_q, mode_n, idle;
  route_t                  rt  [LANE_N];
  route_t                  o_q [LANE_N];
  logic [LANE_N-1:0]       o_vld_q, o_vld_n, acc;
  logic [LANE_N-1:0][1:0]  in_part, o_part;
  logic [LANE_N-1:0]       o_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign idle = !(|o_vld_q) && !(|req_vld_i);

  always_comb begin
    mode_n = mode_q;
    if (idle) mode_n = degraded_i;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) mode_q <= 1'b0;
    else        mode_q <= mode_n;
  end

  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    pmi_map u_map (
      .degraded_i (mode_q),
      .addr_i     (req_addr_i[i]),
      .wr_i       (req_wr_i[i]),
      .route_o    (rt[i])
    );

    assign in_part[i] = rt[i].part;
    assign o_part[i]  = o_q[i].part;
    assign o_wr[i]    = o_q[i].wr;

    always_comb begin
      o_vld_n[i] = o_vld_q[i] && !out_rdy_i[i];
      if (acc[i]) o_vld_n[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) o_vld_q[i] <= 1'b0;
      else        o_vld_q[i] <= o_vld_n[i];
    end

    always_ff @(posedge clk) begin
      if (acc[i]) o_q[i] <= rt[i];
    end

    assign out_vld_o[i]  = o_vld_q[i];
    assign out_port_o[i] = o_q[i].port;
    assign out_ctrl_o[i] = o_q[i].ctrl;
    assign out_part_o[i] = o_q[i].part;
    assign out_wr_o[i]   = o_q[i].wr;
    assign out_addr_o[i] = o_q[i].loc;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (out_vld_o[i] && !out_rdy_i[i]) |=>
        (out_vld_o[i] && $stable(out_port_o[i]) && $stable(out_addr_o[i]) &&
         $stable(out_part_o[i])));

    // R8
    stall_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (out_vld_o[i] && !out_rdy_i[i]) |-> !req_rdy_o[i]);

    // R3
    buddy_route_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (out_vld_o[i] && out_part_o[i] == 2'(PART_HI)) |->
        (out_port_o[i] == BUDDY_PORT && out_ctrl_o[i] == ORPHAN_CTRL));

    // R4
    host_route_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (out_vld_o[i] && out_part_o[i] == 2'(PART_HOST)) |->
        (out_port_o[i] == HOST_PORT && out_addr_o[i][ADDR_W-1]));

    // R2
    rem7_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (acc[i] && mode_q && rt[i].part == PART_LO) |->
        (rt[i].port == PORT_W'(req_addr_i[i][DRAM_W-1:GRAN_W] % 7)));
  end

  pmi_excl u_excl (
    .clk       (clk),
    .rst_n     (rst_q),
    .in_vld_i  (req_vld_i),
    .in_wr_i   (req_wr_i),
    .in_part_i (in_part),
    .o_vld_i   (o_vld_q),
    .o_rdy_i   (out_rdy_i),
    .o_wr_i    (o_wr),
    .o_part_i  (o_part),
    .acc_o     (acc),
    .rdy_o     (req_rdy_o)
  );

  // R5
  no_mixed_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(out_vld_o[0] && out_vld_o[1] && !out_wr_o[0] && !out_wr_o[1] &&
      out_part_o[0] != 2'(PART_HOST) && out_part_o[1] != 2'(PART_HOST) &&
      out_part_o[0] != out_part_o[1]));

  // R9
  mode_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (|out_vld_o) |=> $stable(mode_q));
endmodule

// File: tb/tb_pmi_interleaver.sv
`timescale 1ns/1ps
module tb_pmi_interleaver;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              degraded;
  logic [1:0]        req_vld, req_rdy, req_wr, out_vld, out_rdy, out_wr;
  logic [1:0][32:0]  req_addr, out_addr;
  logic [1:0][3:0]   out_port;
  logic [1:0][2:0]   out_ctrl;
  logic [1:0][1:0]   out_part;
  int                n_cmp = 0;
  int                n_bad = 0;
  bit                done  = 0;
  bit                deg_m = 0;
  int                hits [8];

  localparam longint LO_TOP = 64'hE000_0000;
  localparam longint G4     = 64'h1_0000_0000;

  always #4 clk = ~clk;

  pmi_interleaver dut (
    .clk (clk), .rst_n (rst_n), .degraded_i (degraded),
    .req_vld_i (req_vld), .req_rdy_o (req_rdy), .req_addr_i (req_addr),
    .req_wr_i (req_wr), .out_vld_o (out_vld), .out_rdy_i (out_rdy),
    .out_port_o (out_port), .out_ctrl_o (out_ctrl), .out_part_o (out_part),
    .out_wr_o (out_wr), .out_addr_o (out_addr)
  );

  function automatic logic [41:0] expect_rt(bit deg, longint a);
    longint g, loc;
    int p, c, t;
    if (a >= G4) begin p = 8; c = 0; t = 2; loc = a; end
    else if (!deg) begin g = a / 1024; p = int'(g % 8); c = p; t = 0; loc = (g / 8) * 1024 + a % 1024; end
    else if (a >= LO_TOP) begin p = 6; c = 7; t = 1; loc = a - LO_TOP; end
    else begin g = a / 1024; p = int'(g % 7); c = p; t = 0; loc = (g / 7) * 1024 + a % 1024; end
    return {4'(p), 3'(c), 2'(t), 33'(loc)};
  endfunction

  function automatic logic [41:0] got_rt(int l);
    return {out_port[l], out_ctrl[l], out_part[l], out_addr[l]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive lane 0 for one cycle and compare the routed result
  task automatic route0(input longint a, input logic w, input string tag);
    req_vld[0] = 1'b1; req_addr[0] = 33'(a); req_wr[0] = w;
    @(negedge clk);
    req_vld[0] = 1'b0;
    chk(tag, {out_vld[0], got_rt(0)}, {1'b1, expect_rt(deg_m, a)});
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; degraded = 1'b0; req_vld = '0; req_wr = '0; req_addr = '0; out_rdy = 2'b11;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(4);

    // R10 reset state
    chk("R10 out_vld", out_vld, 2'b00);
    chk("R10 req_rdy", req_rdy, 2'b11);

    // R1 full-mode rotation over eight ports
    deg_m = 0;
    for (int g = 0; g < 64; g++) route0(longint'(g) * 1024 + (g * 37) % 1024, g[0], "R1 full sweep");
    route0(LO_TOP - 1024, 0, "R1 full below edge");
    route0(LO_TOP, 0, "R1 full at edge");
    route0(G4 - 1, 0, "R1 full top byte");
    // R4 host in full mode
    route0(G4, 0, "R4 host full");
    route0(2 * G4 - 1, 1, "R4 host full top");
    idle_cycles(2);

    // R2 / R11 seven-way striping
    degraded = 1'b1; deg_m = 1;
    idle_cycles(3);
    foreach (hits[p]) hits[p] = 0;
    for (int g = 0; g < 700; g++) begin
      route0(longint'(g) * 1024 + (g * 53) % 1024, 1'b0, "R2 seven-way sweep");
      hits[out_port[0] & 4'h7]++;
      if (g > 0) chk("R11 no repeat", {63'd0, out_port[0] == 4'((g - 1) % 7)}, 64'd0);
    end
    for (int p = 0; p < 7; p++) chk("R11 even share", 64'(hits[p]), 64'd100);
    chk("R11 port7 unused", 64'(hits[7]), 64'd0);
    for (int k = 60; k > 0; k--) route0(LO_TOP - longint'(k) * 1024 + k, 1'b0, "R2 near edge");
    route0(LO_TOP - 1, 0, "R2 last lower byte");
    // R3 buddy partition
    route0(LO_TOP, 0, "R3 first upper byte");
    route0(G4 - 1, 0, "R3 last upper byte");
    for (int k = 0; k < 32; k++) route0(LO_TOP + longint'(k) * 64'h100_0000 + k * 13, k[0], "R3 upper sweep");
    // R4 host in degraded mode
    route0(G4, 0, "R4 host degraded");
    route0(G4 + 12345, 1, "R4 host degraded write");
    idle_cycles(2);

    // R6 clash alternation
    req_vld = 2'b11; req_wr = 2'b00;
    req_addr[0] = 33'(5 * 1024); req_addr[1] = 33'(LO_TOP + 256);
    #1 chk("R6 first clash grants lower", req_rdy, 2'b01);
    @(negedge clk); req_vld[0] = 1'b0;
    chk("R6 lower issued alone", out_vld, 2'b01);
    #1 chk("R6 upper then ready", req_rdy[1], 1'b1);
    @(negedge clk); req_vld[1] = 1'b0;
    chk("R6 upper issued", {out_vld, out_part[1]}, {2'b10, 2'd1});
    req_vld = 2'b11;
    #1 chk("R6 second clash grants upper", req_rdy, 2'b10);
    @(negedge clk); req_vld[1] = 1'b0;
    chk("R6 upper first now", out_vld, 2'b10);
    @(negedge clk); req_vld[0] = 1'b0;
    chk("R6 lower follows", {out_vld, out_part[0]}, {2'b01, 2'd0});
    idle_cycles(2);

    // R7 write exemption
    req_vld = 2'b11; req_wr = 2'b01;
    #1 chk("R7 write+read both ready", req_rdy, 2'b11);
    @(negedge clk); req_vld = 2'b00;
    chk("R7 both issued", out_vld, 2'b11);
    req_vld = 2'b11; req_wr = 2'b10;
    #1 chk("R7 read+write both ready", req_rdy, 2'b11);
    @(negedge clk); req_vld = 2'b00; req_wr = 2'b00;
    chk("R7 both issued again", out_vld, 2'b11);
    idle_cycles(2);

    // R8 / R5 backpressure and cross-partition block
    out_rdy[0] = 1'b0;
    req_vld[0] = 1'b1; req_addr[0] = 33'd0;
    @(negedge clk);
    req_addr[0] = 33'd1024;
    req_vld[1] = 1'b1; req_addr[1] = 33'(LO_TOP);
    #1 chk("R8 lane stalled not ready", req_rdy[0], 1'b0);
    chk("R5 opposite read blocked", req_rdy[1], 1'b0);
    req_addr[1] = 33'd2048;
    #1 chk("R5 same-partition read ready", req_rdy[1], 1'b1);
    @(negedge clk); req_vld[1] = 1'b0;
    chk("R8 output held", {out_vld[0], got_rt(0)}, {1'b1, expect_rt(1, 0)});
    chk("R5 lower read on lane1", {out_vld[1], got_rt(1)}, {1'b1, expect_rt(1, 2048)});
    out_rdy[0] = 1'b1;
    @(negedge clk); req_vld[0] = 1'b0;
    chk("R8 next after release", {out_vld[0], got_rt(0)}, {1'b1, expect_rt(1, 1024)});
    idle_cycles(2);

    // R9 mode change deferred until idle
    out_rdy[0] = 1'b0;
    req_vld[0] = 1'b1; req_addr[0] = 33'd0;
    @(negedge clk); req_vld[0] = 1'b0;
    degraded = 1'b0;
    idle_cycles(2);
    req_vld[1] = 1'b1; req_addr[1] = 33'(9 * 1024);
    @(negedge clk); req_vld[1] = 1'b0;
    chk("R9 busy keeps old mode", {out_vld[1], got_rt(1)}, {1'b1, expect_rt(1, 9 * 1024)});
    out_rdy[0] = 1'b1;
    idle_cycles(3);
    deg_m = 0;
    route0(9 * 1024, 0, "R9 new mode after idle");
    idle_cycles(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule